// File: doc/BRIEF.md
# Programmable Function Unit Dispatcher

This block sits beside a processor register file as an extra functional unit for custom operations. An issued custom instruction presents an 11-bit function identifier and two source operands. The unit compares that identifier with the identifier of the configuration currently loaded. When they agree, the result of the loaded function appears in the same cycle, like any single-cycle ALU result. When they disagree, or when nothing has been loaded yet, the unit raises a fault instead. A trap handler can then install the wanted configuration and retry the instruction.

A load port installs a configuration. A configuration is an identifier paired with a selector that picks one of eight built-in combinational functions; the selector stands in for a real logic fabric. The only state in the unit is the identifier, the selector and a valid flag. No operand data is kept between operations, so nothing has to be saved across a context switch.

Top module: `pfu_dispatch`

## Requirements
- R1: After reset no configuration is valid, so every issued instruction faults until the first load.
- R2: A match needs all 11 identifier bits equal. An identifier that differs in any single bit, including bit 10, faults.
- R3: While `fault` is high, `res_valid` is low and `res_data` is zero.
- R4: When an issued identifier matches a valid configuration, `res_valid` is high and `res_data` holds the function result in the same cycle, with no clock edge in between.
- R5: A load is captured on the clock edge where `cfg_load` is high and takes effect from the next cycle. An instruction issued in the same cycle as the load is judged against the previous configuration.
- R6: The selector encodings are: 0 a+b, 1 a-b, 2 a XOR b, 3 a AND NOT b, 4 count of ones in a XOR b, 5 a with its bit order reversed, 6 a rotated left by b[4:0], 7 the unsigned minimum of a and b. All arithmetic is modulo 2^32.
- R7: With `issue_valid` low, `fault` and `res_valid` are low and `res_data` is zero.
- R8: A result depends only on the present operands and the loaded configuration. The same instruction gives the same result whatever was issued before it.
- R9: A load into a unit that already holds a valid configuration replaces both the identifier and the selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | A custom instruction is issued this cycle |
| issue_fid | input | 11 | Function identifier of the issued instruction |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| cfg_load | input | 1 | Load strobe for a new configuration |
| cfg_fid | input | 11 | Identifier to install |
| cfg_sel | input | 3 | Function selector to install |
| res_valid | output | 1 | Result is valid this cycle |
| res_data | output | 32 | Result value, zero when not valid |
| fault | output | 1 | Issued identifier does not match the loaded configuration |

## Verification
The assertions check on every cycle that fault and a valid result never occur together, that a faulting or idle cycle drives zero data, that an unloaded unit always faults, and that a load becomes visible exactly one cycle later while the registers otherwise hold still. Only the bench can show the arithmetic value of each of the eight functions. The same holds for the single-bit identifier mismatches, the old-configuration outcome of an instruction issued together with a load, and the fact that results carry no history across a mixed random sequence.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
  localparam int FID_W  = 11;
  localparam int SEL_W  = 3;
  localparam int DATA_W = 32;
  localparam int NUM_FN = 1 << SEL_W;

  typedef enum logic [SEL_W-1:0] {
    FN_ADD   = 3'd0,
    FN_SUB   = 3'd1,
    FN_XOR   = 3'd2,
    FN_ANDN  = 3'd3,
    FN_DCNT  = 3'd4,
    FN_BREV  = 3'd5,
    FN_ROTL  = 3'd6,
    FN_MINU  = 3'd7
  } fn_sel_e;
endpackage

// File: rtl/pfu_cfg_reg.sv
module pfu_cfg_reg #(
  parameter int FID_W = 11,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [FID_W-1:0] load_fid,
  input  logic [SEL_W-1:0] load_sel,
  output logic             cur_valid,
  output logic [FID_W-1:0] cur_fid,
  output logic [SEL_W-1:0] cur_sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_valid <= 1'b0;
      cur_fid   <= '0;
      cur_sel   <= '0;
    end else if (load) begin
      cur_valid <= 1'b1;
      cur_fid   <= load_fid;
      cur_sel   <= load_sel;
    end
  end

  AST_LOAD_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    load |=> (cur_valid && cur_fid == $past(load_fid) && cur_sel == $past(load_sel))); // R5
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(cur_fid) && $stable(cur_sel) && $stable(cur_valid))); // R5
endmodule

// File: rtl/pfu_match.sv
module pfu_match #(
  parameter int FID_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_valid,
  input  logic [FID_W-1:0] issue_fid,
  input  logic             cur_valid,
  input  logic [FID_W-1:0] cur_fid,
  output logic             hit,
  output logic             miss
);
  logic same_id;

  always_comb begin
    same_id = (issue_fid == cur_fid);
    hit     = issue_valid && cur_valid && same_id;
    miss    = issue_valid && !hit;
  end

  AST_UNLOADED_FAULTS: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !cur_valid) |-> miss); // R1
  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(hit && miss)); // R3
endmodule

// File: rtl/pfu_func_bank.sv
module pfu_func_bank #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 3
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic [DATA_W-1:0] y
);
  localparam int SH_W   = $clog2(DATA_W);
  localparam int NUM_FN = 1 << SEL_W;

  logic [DATA_W-1:0]   cand [NUM_FN];
  logic [DATA_W-1:0]   rev_a;
  logic [2*DATA_W-1:0] rot_dbl;
  logic [SH_W:0]       ones;
  logic [DATA_W-1:0]   diff;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_rev
      assign rev_a[gi] = op_a[DATA_W-1-gi];
    end
  endgenerate

  always_comb begin
    diff = op_a ^ op_b;
    ones = '0;
    for (int i = 0; i < DATA_W; i++) begin
      ones = ones + {{SH_W{1'b0}}, diff[i]};
    end
    rot_dbl = {op_a, op_a} << op_b[SH_W-1:0];
  end

  always_comb begin
    for (int k = 0; k < NUM_FN; k++) cand[k] = '0;
    cand[0] = op_a + op_b;
    cand[1] = op_a - op_b;
    cand[2] = diff;
    cand[3] = op_a & ~op_b;
    cand[4] = {{(DATA_W-SH_W-1){1'b0}}, ones};
    cand[5] = rev_a;
    cand[6] = rot_dbl[2*DATA_W-1:DATA_W];
    cand[7] = (op_a < op_b) ? op_a : op_b;
    y = cand[sel];
  end
endmodule

// File: rtl/pfu_dispatch.sv
module pfu_dispatch #(
  parameter int FID_W  = pfu_pkg::FID_W,
  parameter int SEL_W  = pfu_pkg::SEL_W,
  parameter int DATA_W = pfu_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [FID_W-1:0]  issue_fid,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic              cfg_load,
  input  logic [FID_W-1:0]  cfg_fid,
  input  logic [SEL_W-1:0]  cfg_sel,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              fault
);
  logic              cur_valid;
  logic [FID_W-1:0]  cur_fid;
  logic [SEL_W-1:0]  cur_sel;
  logic              hit;
  logic              miss;
  logic [DATA_W-1:0] fn_y;

  pfu_cfg_reg #(.FID_W(FID_W), .SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst(rst), .load(cfg_load), .load_fid(cfg_fid), .load_sel(cfg_sel),
    .cur_valid(cur_valid), .cur_fid(cur_fid), .cur_sel(cur_sel)
  );

  pfu_match #(.FID_W(FID_W)) u_match (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_fid(issue_fid),
    .cur_valid(cur_valid), .cur_fid(cur_fid), .hit(hit), .miss(miss)
  );

  pfu_func_bank #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_fn (
    .sel(cur_sel), .op_a(src_a), .op_b(src_b), .y(fn_y)
  );

  always_comb begin
    res_valid = hit;
    fault     = miss;
    res_data  = hit ? fn_y : '0;
  end

  AST_FAULT_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!res_valid && res_data == '0)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |-> (!fault && !res_valid && res_data == '0)); // R7
  AST_ISSUE_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> $onehot({fault, res_valid})); // R4
endmodule

// File: tb/pfu_dispatch_tb.sv
module pfu_dispatch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 11;
  localparam int SW = 3;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          issue_valid;
  logic [FW-1:0] issue_fid;
  logic [DW-1:0] src_a, src_b;
  logic          cfg_load;
  logic [FW-1:0] cfg_fid;
  logic [SW-1:0] cfg_sel;
  logic          res_valid;
  logic [DW-1:0] res_data;
  logic          fault;

  int total = 0;
  int bad   = 0;

  logic          m_valid = 1'b0;
  logic [FW-1:0] m_fid   = '0;
  logic [SW-1:0] m_sel   = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfu_dispatch dut_i (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_fid(issue_fid),
    .src_a(src_a), .src_b(src_b), .cfg_load(cfg_load), .cfg_fid(cfg_fid),
    .cfg_sel(cfg_sel), .res_valid(res_valid), .res_data(res_data), .fault(fault)
  );

  function automatic logic [DW-1:0] ref_fn(input logic [SW-1:0] s,
                                           input logic [DW-1:0] a,
                                           input logic [DW-1:0] b);
    logic [DW-1:0] r;
    r = '0;
    case (s)
      3'd0: r = a + b;
      3'd1: r = a - b;
      3'd2: r = a ^ b;
      3'd3: r = a & ~b;
      3'd4: for (int i = 0; i < DW; i++) r = r + DW'((a[i] ^ b[i]) ? 1 : 0);
      3'd5: for (int i = 0; i < DW; i++) r[i] = a[DW-1-i];
      3'd6: begin
        r = a;
        for (int k = 0; k < int'(b[4:0]); k++) r = {r[DW-2:0], r[DW-1]};
      end
      default: r = (a < b) ? a : b;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [DW+1:0] got, input logic [DW+1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got fault/valid/data=%h expected %h", tag, got, exp);
    end
  endtask

  // Called just after a falling edge; leaves just after the next falling edge.
  task automatic step(input string tag, input logic iv, input logic [FW-1:0] fid,
                      input logic [DW-1:0] a, input logic [DW-1:0] b,
                      input logic ld, input logic [FW-1:0] lfid, input logic [SW-1:0] lsel);
    logic          e_hit;
    logic [DW-1:0] e_data;
    issue_valid = iv; issue_fid = fid; src_a = a; src_b = b;
    cfg_load = ld; cfg_fid = lfid; cfg_sel = lsel;
    #1;
    e_hit  = iv && m_valid && (fid == m_fid);
    e_data = e_hit ? ref_fn(m_sel, a, b) : '0;
    check(tag, {fault, res_valid, res_data}, {iv && !e_hit, e_hit, e_data});
    @(posedge clk);
    if (ld) begin m_valid = 1'b1; m_fid = lfid; m_sel = lsel; end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] ra, rb;
    logic [DW-1:0] first_res;
    void'($urandom(32'd1729));
    rst = 1'b1; issue_valid = 0; issue_fid = '0; src_a = '0; src_b = '0;
    cfg_load = 0; cfg_fid = '0; cfg_sel = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: unloaded unit faults for several identifiers
    step("R1 unloaded id0", 1, 11'h000, 32'd5, 32'd6, 0, '0, '0);
    step("R1 unloaded id7ff", 1, 11'h7ff, 32'd5, 32'd6, 0, '0, '0);
    // R7: idle cycle
    step("R7 idle", 0, 11'h000, 32'hdead_beef, 32'h1, 0, '0, '0);
    // R5: issue together with first load still faults, next cycle hits
    step("R5 same-cycle load", 1, 11'h123, 32'd10, 32'd3, 1, 11'h123, 3'd0);
    step("R5 R4 after load add", 1, 11'h123, 32'd10, 32'd3, 0, '0, '0);
    // R4 R6: each function, directed operands
    for (int s = 0; s < 8; s++) begin
      step("R6 load", 0, '0, '0, '0, 1, 11'h400 + 11'(s), 3'(s));
      step("R6 R4 fn a", 1, 11'h400 + 11'(s), 32'h8000_0001, 32'h0000_0023, 0, '0, '0);
      step("R6 R4 fn b", 1, 11'h400 + 11'(s), 32'h0f0f_00ff, 32'hffff_fff4, 0, '0, '0);
      step("R6 R4 fn zero", 1, 11'h400 + 11'(s), 32'h0, 32'h0, 0, '0, '0);
    end
    // R2: single-bit mismatches, including the top bit
    step("R2 load", 0, '0, '0, '0, 1, 11'h2a5, 3'd2);
    step("R2 R3 bit10 differs", 1, 11'h6a5, 32'h1, 32'h2, 0, '0, '0);
    step("R2 R3 bit0 differs", 1, 11'h2a4, 32'h1, 32'h2, 0, '0, '0);
    step("R2 exact match", 1, 11'h2a5, 32'h1, 32'h2, 0, '0, '0);
    // R9: reload replaces id and selector; old id now faults
    step("R9 same-cycle reload uses old", 1, 11'h2a5, 32'h7, 32'h9, 1, 11'h011, 3'd7);
    step("R9 old id faults", 1, 11'h2a5, 32'h7, 32'h9, 0, '0, '0);
    step("R9 new id new fn", 1, 11'h011, 32'h7, 32'h9, 0, '0, '0);
    // R8: same instruction after unrelated traffic gives the same answer
    step("R8 load rot", 0, '0, '0, '0, 1, 11'h055, 3'd6);
    step("R8 first", 1, 11'h055, 32'h1234_5678, 32'd13, 0, '0, '0);
    first_res = res_data;
    step("R8 noise", 1, 11'h055, 32'hffff_ffff, 32'd31, 0, '0, '0);
    step("R8 noise miss", 1, 11'h056, 32'h0, 32'd1, 0, '0, '0);
    step("R8 repeat", 1, 11'h055, 32'h1234_5678, 32'd13, 0, '0, '0);
    total++;
    if (res_data !== first_res && !fault) begin
      bad++;
      $display("FAIL R8 history: got %h expected %h", res_data, first_res);
    end
    // Random mix: loads, hits, misses, idles
    for (int n = 0; n < 600; n++) begin
      logic          iv, ld;
      logic [FW-1:0] fid, lfid;
      ra = $urandom; rb = $urandom;
      iv = ($urandom % 8) != 0;
      ld = ($urandom % 5) == 0;
      fid  = (($urandom % 3) != 0) ? m_fid : FW'($urandom);
      lfid = (($urandom % 2) == 0) ? FW'($urandom % 4) : FW'($urandom);
      step("R4 R3 random", iv, fid, ra, rb, ld, lfid, SW'($urandom));
    end
    // R1: reset clears the configuration again
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_valid = 1'b0; m_fid = '0; m_sel = '0;
    step("R1 after second reset", 1, 11'h000, 32'h3, 32'h4, 0, '0, '0);
    issue_valid = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule